// File: doc/BRIEF.md
# Bit-Exact 8x8 Integer Inverse Transform

This block turns an 8x8 block of dequantized transform coefficients into 64 residual samples for a video decoder. It applies the one-dimensional eight-point integer inverse transform to each row and then to each column of the row results. It defines its arithmetic exactly, so every implementation gives identical samples for any input, including corrupt streams that overflow intermediate values. An encoder's reconstruction loop therefore stays in step with the decoder.

Coefficients enter one per cycle on a valid/ready stream in row-major order. The index is 8*row + column. One shared eight-point datapath first processes a whole row per cycle into a transpose buffer. It then processes a whole column per cycle into an output buffer. Results leave on a second valid/ready stream in the same row-major order. The next block may load while the current block is in its column pass or still being drained.

Arithmetic is defined as follows. Inputs are sign-extended to 16 bits. Every sum or difference is kept modulo 2^16 as a signed value. A constant product M(K,x) is (x*K) arithmetically shifted right by 16, also kept to 16 bits, where K is an unsigned 16-bit constant: K1=64277, K2=60547, K3=54491, K4=46341, K5=36410, K6=25080, K7=12785.

The eight-point flowgraph on x0..x7 is:
- P=M(K1,x1)+M(K7,x7), Q=M(K7,x1)-M(K1,x7), R=M(K3,x3)+M(K5,x5), S=M(K3,x5)-M(K5,x3).
- Pr=M(K4,P-R), Qs=M(K4,Q-S), T=P+R, U=Q+S.
- V=M(K4,x0+x4), W=M(K4,x0-x4), Y=M(K2,x2)+M(K6,x6), Z=M(K6,x2)-M(K2,x6).
- Vm=V-Y, Vp=V+Y, Wp=W+Pr, Qz=Qs-Z, Wm=W-Pr, Qp=Qs+Z.
- Outputs: y0=Vp+T, y7=Vp-T, y1=Wp+Qp, y2=Wp-Qp, y3=Vm+U, y4=Vm-U, y5=Wm+Qz, y6=Wm-Qz.

Top module: `idct8x8`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each coefficient is a signed 14-bit value. Coefficient k of a block (k = 8*row + column, 0..63) is the k-th one accepted. A transfer happens on a rising edge where in_valid and in_ready are both 1.
- R3: Every addition and subtraction in the flowgraph wraps to 16-bit two's complement. Overflow never saturates.
- R4: Every constant product is the signed 16-bit operand times the full unsigned 16-bit constant, arithmetically shifted right by 16 and kept to 16 bits.
- R5: The row pass applies the flowgraph to each input row and stores the eight 16-bit results unscaled. The column pass applies it to each column of those results. Each column result v yields output (v + 8) >>> 4, computed at 17 bits, so every sample lies in -2048..2048.
- R6: Output samples are bit-exact with the flowgraph above for every input, including all-extreme blocks that overflow.
- R7: Outputs leave in row-major order. While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R8: in_ready is 0 for the 8 cycles of the row pass, which starts at the edge that accepts the 64th coefficient. A coefficient offered while in_ready is 0 is ignored. in_ready returns to 1 when the column pass starts. At most one further block is accepted before the current block is fully drained.
- R9: out_valid rises 16 clock edges after the edge that accepts a block's 64th coefficient, provided the previous block has been drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Coefficient offered |
| in_ready | output | 1 | Block can take a coefficient |
| in_data | input | CW (14) | Signed coefficient |
| out_valid | output | 1 | Residual sample available |
| out_ready | input | 1 | Consumer takes the sample |
| out_data | output | 16 | Signed residual sample |

## Verification
On every cycle the assertions check four things: the idle state after reset, the hold of a stalled output, the output range that the final rounding shift guarantees, and the limit of one block loaded ahead of the block being drained. Only the bench's scenarios can show bit-exactness of the wrapped arithmetic and the constant products. It compares each block against a separately written integer model, using random, single-coefficient, constant-extreme and alternating-extreme blocks. The same scenarios cover the sixteen-edge latency, the refusal of coefficients during the row pass, and loading the next block while the current one drains under random stalls.

// File: rtl/idct8x8.sv
module idct8x8 #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data
);
  localparam int N  = 8;
  localparam int NN = N * N;
  localparam logic [15:0] K1 = 16'd64277;
  localparam logic [15:0] K2 = 16'd60547;
  localparam logic [15:0] K3 = 16'd54491;
  localparam logic [15:0] K4 = 16'd46341;
  localparam logic [15:0] K5 = 16'd36410;
  localparam logic [15:0] K6 = 16'd25080;
  localparam logic [15:0] K7 = 16'd12785;

  typedef logic [N-1:0][15:0] vec_t;
  typedef enum logic [1:0] {S_LOAD, S_ROW, S_COL, S_OUT} st_t;

  st_t        st;
  logic [6:0] in_cnt;
  logic [2:0] pass;
  logic [5:0] out_cnt;
  logic [15:0] ibuf [NN];
  logic [15:0] tbuf [NN];
  logic [15:0] obuf [NN];
  vec_t xin, y;
  logic acc, go_row, last_out;

  function automatic logic [15:0] mc(input logic [15:0] k, input logic [15:0] x);
    logic signed [32:0] p;
    p = $signed({17'd0, k}) * $signed({{17{x[15]}}, x});
    return p[31:16];
  endfunction

  function automatic logic [15:0] fin(input logic [15:0] v);
    logic signed [16:0] t;
    t = $signed({v[15], v}) + 17'sd8;
    t = t >>> 4;
    return t[15:0];
  endfunction

  function automatic vec_t idct1d(input vec_t x);
    logic [15:0] p, q, r, s, pr, qs, t, u, v, w, yy, z;
    logic [15:0] vm, vp, wp, qz, wm, qp, ps, qd;
    vec_t o;
    p  = mc(K1, x[1]) + mc(K7, x[7]);
    q  = mc(K7, x[1]) - mc(K1, x[7]);
    r  = mc(K3, x[3]) + mc(K5, x[5]);
    s  = mc(K3, x[5]) - mc(K5, x[3]);
    ps = p - r;
    qd = q - s;
    pr = mc(K4, ps);
    qs = mc(K4, qd);
    t  = p + r;
    u  = q + s;
    v  = mc(K4, x[0] + x[4]);
    w  = mc(K4, x[0] - x[4]);
    yy = mc(K2, x[2]) + mc(K6, x[6]);
    z  = mc(K6, x[2]) - mc(K2, x[6]);
    vm = v - yy;
    vp = v + yy;
    wp = w + pr;
    qz = qs - z;
    wm = w - pr;
    qp = qs + z;
    o[0] = vp + t;
    o[7] = vp - t;
    o[1] = wp + qp;
    o[2] = wp - qp;
    o[3] = vm + u;
    o[4] = vm - u;
    o[5] = wm + qz;
    o[6] = wm - qz;
    return o;
  endfunction

  assign in_ready  = !in_cnt[6] && st != S_ROW;
  assign acc       = in_valid && in_ready;
  assign go_row    = in_cnt[6] || (acc && in_cnt == 7'd63);
  assign last_out  = st == S_OUT && out_ready && out_cnt == 6'd63;
  assign out_valid = st == S_OUT;
  assign out_data  = obuf[out_cnt];

  always_comb begin
    for (int k = 0; k < N; k++)
      xin[k] = (st == S_COL) ? tbuf[{3'(k), pass}] : ibuf[{pass, 3'(k)}];
  end

  assign y = idct1d(xin);

  always_ff @(posedge clk) begin
    if (acc) ibuf[in_cnt[5:0]] <= {{(16-CW){in_data[CW-1]}}, in_data};
    if (st == S_ROW)
      for (int k = 0; k < N; k++) tbuf[{pass, 3'(k)}] <= y[k];
    if (st == S_COL)
      for (int k = 0; k < N; k++) obuf[{3'(k), pass}] <= fin(y[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_LOAD;
      in_cnt  <= '0;
      pass    <= '0;
      out_cnt <= '0;
    end else begin
      case (st)
        S_LOAD: if (go_row) st <= S_ROW;
        S_ROW: begin
          pass <= pass + 3'd1;
          if (pass == 3'd7) st <= S_COL;
        end
        S_COL: begin
          pass <= pass + 3'd1;
          if (pass == 3'd7) st <= S_OUT;
        end
        default: if (out_ready) begin
          out_cnt <= out_cnt + 6'd1;
          if (out_cnt == 6'd63) st <= go_row ? S_ROW : S_LOAD;
        end
      endcase
      if ((st == S_LOAD || last_out) && go_row) in_cnt <= '0;
      else if (acc)                              in_cnt <= in_cnt + 7'd1;
    end
  end
endmodule

// File: rtl/idct8x8_chk.sv
module idct8x8_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data
);
  int unsigned acc_n, done_n;
  logic [5:0]  oc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_n  <= 0;
      done_n <= 0;
      oc     <= '0;
    end else begin
      if (in_valid && in_ready) acc_n <= acc_n + 1;
      if (out_valid && out_ready) begin
        oc <= oc + 6'd1;
        if (oc == 6'd63) done_n <= done_n + 1;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_out_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_data) >= -16'sd2048 && $signed(out_data) <= 16'sd2048));

  a_r8_one_block_ahead: assert property (@(posedge clk) disable iff (rst)
    (acc_n - 64 * done_n) <= 128);
endmodule

bind idct8x8 idct8x8_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_idct8x8.sv
module sim_idct8x8;
  localparam int NP = 12;
  localparam int PAT [NP][2] = '{
    '{6, 0}, '{0, 0}, '{1, 8191}, '{1, -8192}, '{2, 0}, '{3, 0},
    '{4, 0}, '{5, 7}, '{5, 99}, '{7, 3}, '{6, 63}, '{6, 9}
  };

  logic        clk = 0;
  logic        rst;
  logic        in_valid, out_ready;
  logic        in_ready, out_valid;
  logic [13:0] in_data;
  logic [15:0] out_data;
  int checks = 0, fails = 0;
  int ins [NP][64];
  int exps[NP][64];
  int rs_s = 11, rs_r = 23;
  bit finished = 0;

  always #4 clk = ~clk;

  idct8x8 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic int nxt(inout int s);
    s = s * 1103515245 + 12345;
    return (s >>> 16) & 32767;
  endfunction

  function automatic int w16(int v);
    return int'(shortint'(v));
  endfunction

  function automatic int mm(int k, int x);
    longint p;
    p = longint'(k) * longint'(x);
    return w16(int'(p >>> 16));
  endfunction

  function automatic void f1d(inout int x[8]);
    int p, q, r, s, pr, qs, t, u, v, w, yy, z, vm, vp, wp, qz, wm, qp;
    p  = w16(mm(64277, x[1]) + mm(12785, x[7]));
    q  = w16(mm(12785, x[1]) - mm(64277, x[7]));
    r  = w16(mm(54491, x[3]) + mm(36410, x[5]));
    s  = w16(mm(54491, x[5]) - mm(36410, x[3]));
    pr = mm(46341, w16(p - r));
    qs = mm(46341, w16(q - s));
    t  = w16(p + r);
    u  = w16(q + s);
    v  = mm(46341, w16(x[0] + x[4]));
    w  = mm(46341, w16(x[0] - x[4]));
    yy = w16(mm(60547, x[2]) + mm(25080, x[6]));
    z  = w16(mm(25080, x[2]) - mm(60547, x[6]));
    vm = w16(v - yy);  vp = w16(v + yy);
    wp = w16(w + pr);  qz = w16(qs - z);
    wm = w16(w - pr);  qp = w16(qs + z);
    x[0] = w16(vp + t);  x[7] = w16(vp - t);
    x[1] = w16(wp + qp); x[2] = w16(wp - qp);
    x[3] = w16(vm + u);  x[4] = w16(vm - u);
    x[5] = w16(wm + qz); x[6] = w16(wm - qz);
  endfunction

  function automatic void build(int b);
    int kind, seed, rs, m[64], v[8];
    kind = PAT[b][0]; seed = PAT[b][1]; rs = seed;
    for (int i = 0; i < 64; i++) begin
      case (kind)
        0: ins[b][i] = 0;
        1: ins[b][i] = (i == 0) ? seed : 0;
        2: ins[b][i] = 8191;
        3: ins[b][i] = -8192;
        4: ins[b][i] = (((i + i / 8) % 2) == 1) ? 8191 : -8192;
        5: ins[b][i] = (nxt(rs) & 16383) - 8192;
        6: ins[b][i] = (i == seed) ? 8191 : 0;
        default: ins[b][i] = ((nxt(rs) & 1) == 1) ? 8191 : -8192;
      endcase
    end
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) v[c] = ins[b][8*r + c];
      f1d(v);
      for (int c = 0; c < 8; c++) m[8*r + c] = v[c];
    end
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) v[r] = m[8*r + c];
      f1d(v);
      for (int r = 0; r < 8; r++) exps[b][8*r + c] = (v[r] + 8) >>> 4;
    end
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_block(int b, bit gaps);
    for (int i = 0; i < 64; i++) begin
      if (gaps && (nxt(rs_s) % 5) == 0) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_data  = 14'(ins[b][i]);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic recv_block(int b);
    int i;
    logic [15:0] held;
    i = 0;
    while (i < 64) begin
      out_ready = (nxt(rs_r) % 4) != 0;
      if (out_valid && !out_ready) begin
        held = out_data;
        @(negedge clk);
        chk(out_valid && out_data == held, "R7 stall hold",
            int'($signed(out_data)), int'($signed(held)));
      end else begin
        if (out_valid) begin
          // R3 R4 R5 R6: bit-exact sample in row-major order (R2 R7)
          chk(int'($signed(out_data)) == exps[b][i], "R6 sample",
              int'($signed(out_data)), exps[b][i]);
          i++;
        end
        @(negedge clk);
      end
    end
    out_ready = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1; in_valid = 0; out_ready = 0; in_data = '0;
    for (int b = 0; b < NP; b++) build(b);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);

    send_block(0, 0);
    for (int k = 0; k <= 16; k++) begin
      if (k <= 8) chk(in_ready == (k >= 8), "R8 ready in row pass", int'(in_ready), int'(k >= 8));
      if (k >= 15) chk(out_valid == (k == 16), "R9 latency", int'(out_valid), int'(k == 16));
      in_valid = (k < 8);
      in_data  = 14'h1555;
      if (k < 16) @(negedge clk);
    end
    in_valid = 0;
    recv_block(0);

    fork
      begin
        for (int b = 1; b < NP; b++) send_block(b, 1);
      end
      begin
        for (int b = 1; b < NP; b++) recv_block(b);
      end
    join

    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R8 nothing stray accepted", int'(out_valid), 0);
    summary();
  end
endmodule